// File: doc/BRIEF.md
# Indirect PHY Register Access Master

This block carries out one read or one write of an internal PHY control register at a time. It sits between a simple requester and a register bus. A PHY register is never addressed directly. The PHY exposes a small window on the bus. A page register inside that window picks the device and the high part of an internal address, and a word offset inside the window picks the low part. On top of that window sits a command port made of three internal registers: a control register, an address register and a data register. The block reaches the target PHY register by driving this command port.

Each access to an internal register takes two bus writes or reads. The first is a page write, and the second is the data access at the computed offset. A requested read first waits until the command port is idle. It then loads the target address, issues a read command, waits again for the port to go idle, and fetches the data register. A requested write waits for idle, loads the address and the data, and issues the write command without waiting afterwards. The requester sees a one-cycle completion strobe, and a read result along with it. An error flag goes with that strobe when a busy wait runs past its limit.

Top module: `phy_indirect_master`

## Requirements
- R1: After reset the outputs `bus_valid`, `done` and `err` are low and `rdata` is zero.
- R2: Every access to an internal register is immediately preceded by a bus write to window offset 0x800. The data of that write is `{dev_sel, iaddr[15:9]}`, which is `(dev << 7) | ((iaddr >> 9) & 0x7F)`.
- R3: The access to internal register `iaddr` uses window offset `(iaddr & 0x1FF) << 2`. The control register is at 0x80A0 (offset 0x280), the address register at 0x80A1 (offset 0x284) and the data register at 0x80A2 (offset 0x288).
- R4: A read runs these steps in order: wait for idle, write the target address to 0x80A1, write the read command to 0x80A0, wait for idle, read 0x80A2. The value read from 0x80A2 appears on `rdata` in the same cycle as `done`.
- R5: A write runs these steps in order: wait for idle, write the target address to 0x80A1, write the data to 0x80A2, write the write command to 0x80A0. No poll or any other bus access follows the command.
- R6: A wait for idle reads 0x80A0 again and again while bit 0 of the returned data is 1. It moves on after the first read that returns bit 0 = 0.
- R7: The read command value is 0x0001 (start bit 0). The write command value is 0x0003 (start bit 0 plus write-select bit 1).
- R8: `done` goes high for exactly one cycle. That cycle is the one after the bus handshake that ends the transaction.
- R9: A request that arrives while a transaction is in progress is ignored. The bus sequence of the current transaction does not change, and no extra bus access follows.
- R10: When POLL_LIMIT reads in a row inside one idle wait all return busy, the transaction ends. `done` and `err` are high together and no further bus access is made. `err` is low on every other completion.
- R11: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_write`, `bus_addr` and `bus_wdata` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_sel | input | 5 | PHY device select, held stable during a transaction |
| req_valid | input | 1 | Start a transaction (sampled when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Target internal PHY register address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Busy-wait timeout, valid with done |
| rdata | output | 16 | Read result, valid with done on a read |
| bus_valid | output | 1 | Bus access request |
| bus_write | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | 12 | Window offset |
| bus_wdata | output | DW | Bus write data |
| bus_ready | input | 1 | Bus access accepted / read data valid |
| bus_rdata | input | DW | Bus read data |

## Verification
The bench plays the PHY side of the bus. It keeps a busy count for the command port, and it stalls the bus at irregular points. Its model predicts every bus access in order and the cycle in which `done` is due. This catches a design that omits or misplaces a page write, or that computes the page from the wrong address bits. It also catches a design that skips the second wait on a read, or that adds one after a write.

The tests include waits of zero polls, of several polls, of exactly one poll short of the limit, and of exactly the limit. The limit case is tested both before and after the command. An off-by-one in the timeout counter would turn a boundary success into an error, or the reverse. A design that kept going after a timeout would show up as an unexpected bus access.

One test sends a second request while a transaction is running. A design that accepted it would change the predicted sequence of bus accesses.

// File: rtl/phy_indirect_master.sv
module phy_indirect_master #(
  parameter int DW         = 16,
  parameter int POLL_LIMIT = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    dev_sel,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [15:0]   req_addr,
  input  logic [15:0]   req_wdata,
  output logic          done,
  output logic          err,
  output logic [15:0]   rdata,
  output logic          bus_valid,
  output logic          bus_write,
  output logic [11:0]   bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic [DW-1:0] bus_rdata
);

  localparam int          CW       = $clog2(POLL_LIMIT + 1);
  localparam logic [15:0] REG_CTL  = 16'h80A0;
  localparam logic [15:0] REG_ADR  = 16'h80A1;
  localparam logic [15:0] REG_DAT  = 16'h80A2;
  localparam logic [11:0] WIN_PAGE = 12'h800;
  localparam logic [15:0] CMD_RD   = 16'h0001;
  localparam logic [15:0] CMD_WR   = 16'h0003;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT_PRE, S_ADDR, S_WDATA, S_CMD, S_WAIT_POST, S_RDATA
  } step_t;

  step_t          step;
  logic           acc_ph;
  logic           op_wr;
  logic [15:0]    op_addr;
  logic [15:0]    op_wdata;
  logic [CW-1:0]  busy_cnt;
  logic           done_q;
  logic           err_q;
  logic [15:0]    rdata_q;

  logic [15:0]    reg_sel;
  logic           acc_wr;
  logic [15:0]    acc_data;
  logic [11:0]    page_val;
  logic           hs;
  logic           port_busy;
  logic           last_try;

  always_comb begin
    reg_sel  = REG_CTL;
    acc_wr   = 1'b0;
    acc_data = '0;
    case (step)
      S_ADDR:  begin reg_sel = REG_ADR; acc_wr = 1'b1; acc_data = op_addr;  end
      S_WDATA: begin reg_sel = REG_DAT; acc_wr = 1'b1; acc_data = op_wdata; end
      S_CMD:   begin reg_sel = REG_CTL; acc_wr = 1'b1; acc_data = op_wr ? CMD_WR : CMD_RD; end
      S_RDATA: reg_sel = REG_DAT;
      default: reg_sel = REG_CTL;
    endcase
  end

  assign page_val  = {dev_sel, reg_sel[15:9]};
  assign bus_valid = (step != S_IDLE);
  assign bus_write = acc_ph ? acc_wr : 1'b1;
  assign bus_addr  = acc_ph ? {1'b0, reg_sel[8:0], 2'b00} : WIN_PAGE;
  assign bus_wdata = acc_ph ? DW'(acc_data) : DW'(page_val);
  assign hs        = bus_valid && bus_ready;
  assign port_busy = bus_rdata[0];
  assign last_try  = (busy_cnt == CW'(POLL_LIMIT - 1));

  assign done  = done_q;
  assign err   = err_q;
  assign rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step     <= S_IDLE;
      acc_ph   <= 1'b0;
      op_wr    <= 1'b0;
      op_addr  <= '0;
      op_wdata <= '0;
      busy_cnt <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (step == S_IDLE) begin
        if (req_valid) begin
          step     <= S_WAIT_PRE;
          acc_ph   <= 1'b0;
          busy_cnt <= '0;
          op_wr    <= req_write;
          op_addr  <= req_addr;
          op_wdata <= req_wdata;
        end
      end else if (hs) begin
        acc_ph <= ~acc_ph;
        if (acc_ph) begin
          case (step)
            S_WAIT_PRE, S_WAIT_POST: begin
              if (port_busy) begin
                if (last_try) begin
                  step   <= S_IDLE;
                  done_q <= 1'b1;
                  err_q  <= 1'b1;
                end else begin
                  busy_cnt <= busy_cnt + 1'b1;
                end
              end else begin
                busy_cnt <= '0;
                step     <= (step == S_WAIT_PRE) ? S_ADDR : S_RDATA;
              end
            end
            S_ADDR:  step <= op_wr ? S_WDATA : S_CMD;
            S_WDATA: step <= S_CMD;
            S_CMD: begin
              if (op_wr) begin
                step   <= S_IDLE;
                done_q <= 1'b1;
              end else begin
                step <= S_WAIT_POST;
              end
            end
            S_RDATA: begin
              rdata_q <= bus_rdata[15:0];
              step    <= S_IDLE;
              done_q  <= 1'b1;
            end
            default: step <= S_IDLE;
          endcase
        end
      end
    end
  end

  logic pg_seen;
  always_ff @(posedge clk) begin
    if (!rst_n)  pg_seen <= 1'b0;
    else if (hs) pg_seen <= bus_write && (bus_addr == WIN_PAGE);
  end

  assert_page_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr != WIN_PAGE) |-> pg_seen);

  assert_page_dev_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr == WIN_PAGE) |-> (bus_wdata[11:7] == dev_sel && bus_write));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write)));

  assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !bus_valid);

endmodule

// File: tb/phy_indirect_master_test.sv
module phy_indirect_master_test;
  localparam int LIM = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  dev_sel;
  logic        req_valid, req_write;
  logic [15:0] req_addr, req_wdata;
  logic        done, err;
  logic [15:0] rdata;
  logic        bus_valid, bus_write;
  logic [11:0] bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_ready;
  logic [15:0] bus_rdata;

  always #5 clk = ~clk;

  phy_indirect_master #(.DW(16), .POLL_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .err(err), .rdata(rdata),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [11:0] q_addr[$];
  logic        q_wr[$];
  logic [15:0] q_wd[$];
  int          q_end[$];
  string       q_tag[$];
  int          exp_pend = 0;
  logic        exp_is_rd = 1'b0;
  logic [15:0] exp_rdata = '0;
  int          busy_left = 0, busy_post = 0;
  logic [15:0] phy_val = '0;
  bit          ready_always = 1'b0;
  bit          seen_done = 1'b0;
  bit          finished = 1'b0;
  bit          prev_stall = 1'b0;
  logic [11:0] prev_addr;
  logic [15:0] prev_wd;
  logic        prev_wr;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void push_touch(input logic [4:0] d, input logic [15:0] ia, input logic wr,
                                     input logic [15:0] wd, input int fin, input string tag);
    q_addr.push_back(12'h800); q_wr.push_back(1'b1);
    q_wd.push_back({4'b0, d, ia[15:9]}); q_end.push_back(0); q_tag.push_back("R2");
    q_addr.push_back({1'b0, ia[8:0], 2'b00}); q_wr.push_back(wr);
    q_wd.push_back(wd); q_end.push_back(fin); q_tag.push_back(tag);
  endfunction

  function automatic bit push_wait(input logic [4:0] d, input int busy);
    if (busy >= LIM) begin
      for (int i = 0; i < LIM; i++) push_touch(d, 16'h80A0, 1'b0, '0, (i == LIM - 1) ? 2 : 0, "R6");
      return 1'b1;
    end
    for (int i = 0; i <= busy; i++) push_touch(d, 16'h80A0, 1'b0, '0, 0, "R6");
    return 1'b0;
  endfunction

  task automatic run(input bit wr, input logic [15:0] a, input logic [15:0] wd, input logic [4:0] d,
                     input int pre, input int post, input logic [15:0] val, input bit spur, input string tag);
    @(negedge clk);
    dev_sel = d; busy_left = pre; busy_post = post; phy_val = val;
    exp_is_rd = !wr; exp_rdata = val;
    if (!push_wait(d, pre)) begin
      push_touch(d, 16'h80A1, 1'b1, a, 0, "R3");
      if (wr) begin
        push_touch(d, 16'h80A2, 1'b1, wd, 0, tag);
        push_touch(d, 16'h80A0, 1'b1, 16'h0003, 1, "R7");
      end else begin
        push_touch(d, 16'h80A0, 1'b1, 16'h0001, 0, "R7");
        if (!push_wait(d, post)) push_touch(d, 16'h80A2, 1'b0, '0, 1, tag);
      end
    end
    seen_done = 1'b0;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (spur) begin
      repeat (3) @(negedge clk);
      req_valid = 1'b1; req_write = !wr; req_addr = ~a; req_wdata = ~wd;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (!seen_done) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(q_addr.size() == 0, "R9", "leftover expected accesses", q_addr.size(), 0);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      chk(done == (exp_pend != 0), "R8", "done", done, exp_pend != 0);
      chk(err == (exp_pend == 2), "R10", "err", err, exp_pend == 2);
      if (exp_pend == 1 && exp_is_rd) chk(rdata == exp_rdata, "R4", "rdata", rdata, exp_rdata);
      if (exp_pend != 0) seen_done = 1'b1;
      exp_pend = 0;
      if (prev_stall)
        chk(bus_valid && bus_addr == prev_addr && bus_wdata == prev_wd && bus_write == prev_wr,
            "R11", "stalled access changed", {bus_valid, bus_addr}, {1'b1, prev_addr});
      if (bus_valid) begin
        if (bus_addr == 12'h280 && !bus_write)      bus_rdata = {15'b0, busy_left > 0};
        else if (bus_addr == 12'h288 && !bus_write) bus_rdata = phy_val;
        else                                        bus_rdata = '0;
        bus_ready = ready_always || (cyc % 4 != 2);
        prev_stall = !bus_ready;
        prev_addr = bus_addr; prev_wd = bus_wdata; prev_wr = bus_write;
        if (bus_ready) begin
          if (q_addr.size() == 0) begin
            chk(1'b0, "R9", "unexpected bus access", bus_addr, 0);
          end else begin
            logic [11:0] ea; logic ew; logic [15:0] ed; int ef; string et;
            ea = q_addr.pop_front(); ew = q_wr.pop_front(); ed = q_wd.pop_front();
            ef = q_end.pop_front(); et = q_tag.pop_front();
            chk(bus_addr == ea, et, "bus_addr", bus_addr, ea);
            chk(bus_write == ew, et, "bus_write", bus_write, ew);
            if (ew) chk(bus_wdata == ed, et, "bus_wdata", bus_wdata, ed);
            exp_pend = ef;
          end
          if (bus_addr == 12'h280 && !bus_write && busy_left > 0) busy_left--;
          if (bus_addr == 12'h280 && bus_write && bus_wdata[0]) busy_left = busy_post;
        end
      end else begin
        bus_ready = 1'b0;
        bus_rdata = '0;
        prev_stall = 1'b0;
      end
    end
  end

  initial begin
    rst_n = 1'b0; dev_sel = '0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; bus_ready = 1'b0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!bus_valid, "R1", "bus_valid after reset", bus_valid, 0);
    chk(rdata == 16'h0, "R1", "rdata after reset", rdata, 0);
    run(1'b0, 16'h1234, 16'h0, 5'd5, 0, 0, 16'hBEEF, 1'b0, "R4");
    run(1'b0, 16'hA5C3, 16'h0, 5'd17, 2, 3, 16'h0F0F, 1'b0, "R4");
    run(1'b1, 16'hFFFF, 16'h5A5A, 5'h1F, 1, 0, 16'h0, 1'b0, "R5");
    run(1'b1, 16'h0200, 16'h1357, 5'd0, 0, 0, 16'h0, 1'b1, "R9");
    run(1'b0, 16'h4321, 16'h0, 5'd3, LIM, 0, 16'h7777, 1'b0, "R10");
    run(1'b0, 16'h0042, 16'h0, 5'd9, 0, LIM, 16'h8888, 1'b0, "R10");
    ready_always = 1'b1;
    run(1'b0, 16'hC0DE, 16'h0, 5'd22, LIM - 1, LIM - 1, 16'h2468, 1'b0, "R4");
    run(1'b1, 16'h01FF, 16'hAAAA, 5'd12, LIM - 1, 0, 16'h0, 1'b1, "R5");
    ready_always = 1'b0;
    run(1'b0, 16'h7E01, 16'h0, 5'd30, 1, 1, 16'hFFFF, 1'b1, "R4");
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule